// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches a small number of on-chip power domains between on and off, always stepping through the same safe order. It drives three registered control vectors. The first is a power-switch vector, where a set bit turns the domain off. The second is an isolation vector, where a clear bit clamps the domain's outputs. The third is an active-low subsystem reset vector. Each domain has a fixed power mask, isolation mask and reset mask, set by parameters. The defaults give three domains: power 0x08 / isolation 0x01 / reset line 16; power 0x04 / isolation 0x02 / reset line 18; and power 0x10 with no isolation or reset bits.

Software starts a sequence with one register write. A hardware state machine then changes only the selected domain's bits, one step at a time. After each step it waits a programmable number of settle cycles, and it raises a one-cycle done strobe when the sequence finishes. The same register bank holds a 32-line software reset vector, which accepts whole-word writes and indexed assert, deassert and pulse commands. A single-cycle write port and a registered read port give access to all state.

Top module: `pdom_seq`

## Requirements
- R1: After reset: power vector all ones, isolation vector all zeros, reset vector all ones, settle register (addr 2) reads 4, status (addr 1) reads 0.
- R2: A write to addr 0 with bit0=1 and the domain index in bits[7:4] powers that domain up. If the write lands on clock edge t and the settle value is S, the domain's power bits clear at edge t+1, its reset bits set at t+S+2, and its isolation bits set at t+2S+3.
- R3: A write to addr 0 with bit0=0 powers the domain down. Its isolation bits clear at t+1, its reset bits clear at t+S+2, and its power bits set at t+2S+3.
- R4: When all three steps apply, `seq_busy` is high from edge t+1 and falls at edge t+3S+4. At that same edge `seq_done` goes high for exactly one cycle.
- R5: A step whose mask is zero for the domain is skipped. It changes nothing, adds no settle wait, and costs one cycle.
- R6: Each step changes only the selected domain's bits. All other bits of every vector hold their value.
- R7: While busy, any bus write except to status is ignored and sets the sticky error flag (status bit2). A start with a domain index >= the domain count is also ignored and sets the flag. Any write to status clears the flag.
- R8: A write to addr 6 carries the reset line index in bits[4:0] and the operation in bits[9:8]: 1 clears the line, 2 sets it, 3 drives it low for exactly one cycle and then high, and 0 does nothing.
- R9: Addr 3, 4 and 5 read and write the power, isolation and software reset vectors, and addr 2 holds the settle count. Read data is registered and shows the addressed register one cycle after the address is presented.
- R10: Status bits[8+d] report domain d as on. At reset this is taken from its power bits (clear means on). The flag is updated when a sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for last cycle's address |
| pwr_off | output | 8 | Power-switch vector, 1 = domain powered down |
| iso_rel | output | 8 | Isolation vector, 0 = isolation active |
| rst_n | output | 32 | Active-low reset lines |
| seq_busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | One-cycle strobe at sequence completion |

## Verification
The ordering properties assume that domain-owned bits of the power and isolation vectors change only through the sequencer. They also assume that a domain's reset line is not toggled by direct writes while its power or isolation edges occur. The stimulus keeps to this: direct writes to the power vector touch only bit 0, which belongs to no domain. Software reset writes and commands are made only while no domain sequence runs, and each such write restores the domain lines to their previous value. Rejected writes during a sequence target the power vector and the start register, and both must leave the vectors unchanged.

// File: rtl/pdom_pkg.sv
package pdom_pkg;
  typedef enum logic [1:0] {
    STEP_PWR = 2'd0,
    STEP_RST = 2'd1,
    STEP_ISO = 2'd2
  } step_kind_e;

  typedef enum logic [1:0] {
    RCMD_NOP      = 2'd0,
    RCMD_CLR      = 2'd1,
    RCMD_SET      = 2'd2,
    RCMD_PULSE    = 2'd3
  } rcmd_e;

  localparam int A_CTRL   = 0;
  localparam int A_STATUS = 1;
  localparam int A_SETTLE = 2;
  localparam int A_PWR    = 3;
  localparam int A_ISO    = 4;
  localparam int A_SWRST  = 5;
  localparam int A_RCMD   = 6;
endpackage

// File: rtl/pdom_sequencer.sv
module pdom_sequencer
  import pdom_pkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int DOM_W   = 2,
  parameter int CNT_W   = 8,
  parameter int PWR_W   = 8,
  parameter int ISO_W   = 8,
  parameter int RST_W   = 32,
  parameter logic [NUM_DOM-1:0][PWR_W-1:0] PM = '0,
  parameter logic [NUM_DOM-1:0][ISO_W-1:0] IM = '0,
  parameter logic [NUM_DOM-1:0][RST_W-1:0] RM = '0,
  parameter logic [PWR_W-1:0] PWR_INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_up,
  input  logic [DOM_W-1:0] start_dom,
  input  logic [CNT_W-1:0] settle,
  output logic             busy,
  output logic             done,
  output logic             fire,
  output step_kind_e       kind,
  output logic             up,
  output logic [DOM_W-1:0] dom,
  output logic [NUM_DOM-1:0] dom_on
);
  localparam logic [1:0] LAST = 2'd3;

  logic             busy_q, done_q, up_q;
  logic [1:0]       step_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DOM_W-1:0] dom_q;
  logic [NUM_DOM-1:0] on_q;
  logic             mask_nz;

  always_comb begin
    kind = step_kind_e'(up_q ? step_q : (2'd2 - step_q));
    case (kind)
      STEP_PWR: mask_nz = |PM[dom_q];
      STEP_RST: mask_nz = |RM[dom_q];
      STEP_ISO: mask_nz = |IM[dom_q];
      default:  mask_nz = 1'b0;
    endcase
  end

  assign fire   = busy_q && (cnt_q == '0) && (step_q != LAST) && mask_nz;
  assign busy   = busy_q;
  assign done   = done_q;
  assign up     = up_q;
  assign dom    = dom_q;
  assign dom_on = on_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      up_q   <= 1'b0;
      step_q <= '0;
      cnt_q  <= '0;
      dom_q  <= '0;
      for (int d = 0; d < NUM_DOM; d++) on_q[d] <= ~|(PWR_INIT & PM[d]);
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          step_q <= '0;
          cnt_q  <= '0;
          up_q   <= start_up;
          dom_q  <= start_dom;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (step_q == LAST) begin
        busy_q      <= 1'b0;
        done_q      <= 1'b1;
        on_q[dom_q] <= up_q;
      end else begin
        step_q <= step_q + 1'b1;
        if (mask_nz) cnt_q <= settle;
      end
    end
  end
endmodule

// File: rtl/pdom_rst_bank.sv
module pdom_rst_bank
  import pdom_pkg::*;
#(
  parameter int RST_W = 32,
  parameter int IDX_W = 5,
  parameter logic [RST_W-1:0] RST_INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [RST_W-1:0] wr_data,
  input  logic             cmd_en,
  input  rcmd_e            cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [RST_W-1:0] seq_clr,
  input  logic [RST_W-1:0] seq_set,
  output logic [RST_W-1:0] rst_n
);
  logic [RST_W-1:0] vec_q, pend_q, vec_d, pend_d, sel;

  always_comb begin
    sel    = '0;
    sel[cmd_idx] = 1'b1;
    pend_d = '0;
    vec_d  = (wr_en ? wr_data : vec_q) | pend_q;
    if (cmd_en) begin
      case (cmd_op)
        RCMD_CLR:   vec_d = vec_d & ~sel;
        RCMD_SET:   vec_d = vec_d | sel;
        RCMD_PULSE: begin
          vec_d  = vec_d & ~sel;
          pend_d = sel;
        end
        default: ;
      endcase
    end
    vec_d = (vec_d & ~seq_clr) | seq_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= RST_INIT;
      pend_q <= '0;
    end else begin
      vec_q  <= vec_d;
      pend_q <= pend_d;
    end
  end

  assign rst_n = vec_q;
endmodule

// File: rtl/pdom_seq.sv
module pdom_seq
  import pdom_pkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int PWR_W   = 8,
  parameter int ISO_W   = 8,
  parameter int RST_W   = 32,
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter logic [CNT_W-1:0] SETTLE_INIT = 4,
  parameter logic [PWR_W-1:0] PWR_INIT    = '1,
  parameter logic [ISO_W-1:0] ISO_INIT    = '0,
  parameter logic [RST_W-1:0] SWRST_INIT  = '1,
  parameter logic [NUM_DOM-1:0][PWR_W-1:0] PM = {8'h10, 8'h04, 8'h08},
  parameter logic [NUM_DOM-1:0][ISO_W-1:0] IM = {8'h00, 8'h02, 8'h01},
  parameter logic [NUM_DOM-1:0][RST_W-1:0] RM = {32'h0, 32'h0004_0000, 32'h0001_0000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PWR_W-1:0]  pwr_off,
  output logic [ISO_W-1:0]  iso_rel,
  output logic [RST_W-1:0]  rst_n,
  output logic              seq_busy,
  output logic              seq_done
);
  localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
  localparam int IDX_W = (RST_W > 1) ? $clog2(RST_W) : 1;

  logic [PWR_W-1:0]   pwr_q;
  logic [ISO_W-1:0]   iso_q;
  logic [CNT_W-1:0]   settle_q;
  logic               err_q;
  logic               busy, fire, s_up;
  step_kind_e         s_kind;
  logic [DOM_W-1:0]   s_dom;
  logic [NUM_DOM-1:0] dom_on;
  logic               wr_ok, dom_ok, start;
  logic [RST_W-1:0]   seq_clr, seq_set;
  logic [DATA_W-1:0]  status;

  assign wr_ok  = bus_we && !busy;
  assign dom_ok = (bus_wdata[7:4] < 4'(NUM_DOM));
  assign start  = wr_ok && (bus_addr == ADDR_W'(A_CTRL)) && dom_ok;

  pdom_sequencer #(
    .NUM_DOM(NUM_DOM), .DOM_W(DOM_W), .CNT_W(CNT_W), .PWR_W(PWR_W),
    .ISO_W(ISO_W), .RST_W(RST_W), .PM(PM), .IM(IM), .RM(RM), .PWR_INIT(PWR_INIT)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_up(bus_wdata[0]),
    .start_dom(bus_wdata[4 +: DOM_W]), .settle(settle_q), .busy(busy),
    .done(seq_done), .fire(fire), .kind(s_kind), .up(s_up), .dom(s_dom),
    .dom_on(dom_on)
  );

  assign seq_clr = (fire && s_kind == STEP_RST && !s_up) ? RM[s_dom] : '0;
  assign seq_set = (fire && s_kind == STEP_RST &&  s_up) ? RM[s_dom] : '0;

  pdom_rst_bank #(.RST_W(RST_W), .IDX_W(IDX_W), .RST_INIT(SWRST_INIT)) u_rst (
    .clk(clk), .rst(rst),
    .wr_en(wr_ok && bus_addr == ADDR_W'(A_SWRST)),
    .wr_data(bus_wdata[RST_W-1:0]),
    .cmd_en(wr_ok && bus_addr == ADDR_W'(A_RCMD)),
    .cmd_op(rcmd_e'(bus_wdata[9:8])),
    .cmd_idx(bus_wdata[IDX_W-1:0]),
    .seq_clr(seq_clr), .seq_set(seq_set), .rst_n(rst_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q    <= PWR_INIT;
      iso_q    <= ISO_INIT;
      settle_q <= SETTLE_INIT;
      err_q    <= 1'b0;
    end else begin
      if (wr_ok && bus_addr == ADDR_W'(A_PWR))
        pwr_q <= bus_wdata[PWR_W-1:0];
      else if (fire && s_kind == STEP_PWR)
        pwr_q <= s_up ? (pwr_q & ~PM[s_dom]) : (pwr_q | PM[s_dom]);

      if (wr_ok && bus_addr == ADDR_W'(A_ISO))
        iso_q <= bus_wdata[ISO_W-1:0];
      else if (fire && s_kind == STEP_ISO)
        iso_q <= s_up ? (iso_q | IM[s_dom]) : (iso_q & ~IM[s_dom]);

      if (wr_ok && bus_addr == ADDR_W'(A_SETTLE))
        settle_q <= bus_wdata[CNT_W-1:0];

      if (bus_we && bus_addr == ADDR_W'(A_STATUS))
        err_q <= 1'b0;
      else if (bus_we && busy)
        err_q <= 1'b1;
      else if (bus_we && bus_addr == ADDR_W'(A_CTRL) && !dom_ok)
        err_q <= 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[0] = busy;
    status[2] = err_q;
    status[8 +: NUM_DOM] = dom_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (int'(bus_addr))
        A_STATUS: bus_rdata <= status;
        A_SETTLE: bus_rdata <= DATA_W'(settle_q);
        A_PWR:    bus_rdata <= DATA_W'(pwr_q);
        A_ISO:    bus_rdata <= DATA_W'(iso_q);
        A_SWRST:  bus_rdata <= DATA_W'(rst_n);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign pwr_off  = pwr_q;
  assign iso_rel  = iso_q;
  assign seq_busy = busy;
endmodule

// File: rtl/pdom_seq_chk.sv
module pdom_seq_chk #(
  parameter int NUM_DOM = 3,
  parameter int PWR_W   = 8,
  parameter int ISO_W   = 8,
  parameter int RST_W   = 32,
  parameter logic [NUM_DOM-1:0][PWR_W-1:0] PM = '0,
  parameter logic [NUM_DOM-1:0][ISO_W-1:0] IM = '0,
  parameter logic [NUM_DOM-1:0][RST_W-1:0] RM = '0
) (
  input logic             clk,
  input logic             rst,
  input logic [PWR_W-1:0] pwr_off,
  input logic [ISO_W-1:0] iso_rel,
  input logic [RST_W-1:0] rst_n,
  input logic             seq_busy,
  input logic             seq_done
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    if (PM[d] != '0 && IM[d] != '0) begin : g_pi
      // R3
      iso_before_cut_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(|(pwr_off & PM[d])) |-> ((iso_rel & IM[d]) == '0));
      // R2
      iso_on_restore_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(|(pwr_off & PM[d])) |-> ((iso_rel & IM[d]) == '0));
    end
    if (PM[d] != '0 && RM[d] != '0) begin : g_pr
      // R3
      rst_before_cut_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(|(pwr_off & PM[d])) |-> ((rst_n & RM[d]) == '0));
    end
    if (IM[d] != '0 && RM[d] != '0) begin : g_ir
      // R2
      rst_before_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(|(iso_rel & IM[d])) |-> ((rst_n & RM[d]) == RM[d]));
    end
  end

  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (!seq_busy && $past(seq_busy)));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);
endmodule

bind pdom_seq pdom_seq_chk #(
  .NUM_DOM(NUM_DOM), .PWR_W(PWR_W), .ISO_W(ISO_W), .RST_W(RST_W),
  .PM(PM), .IM(IM), .RM(RM)
) u_chk (
  .clk(clk), .rst(rst), .pwr_off(pwr_off), .iso_rel(iso_rel),
  .rst_n(rst_n), .seq_busy(seq_busy), .seq_done(seq_done)
);

// File: tb/pdom_seq_test.sv
`timescale 1ns/1ps
module pdom_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pwr_off, iso_rel;
  logic [31:0] rst_n;
  logic        seq_busy, seq_done;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pdom_seq uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_off(pwr_off),
    .iso_rel(iso_rel), .rst_n(rst_n), .seq_busy(seq_busy), .seq_done(seq_done)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd1, 32'h0,        32'h0},         // R1 R10
    '{1'b0, 3'd2, 32'h0,        32'h4},         // R1
    '{1'b0, 3'd3, 32'h0,        32'hFF},        // R1
    '{1'b0, 3'd4, 32'h0,        32'h0},         // R1
    '{1'b0, 3'd5, 32'h0,        32'hFFFF_FFFF}, // R1
    '{1'b1, 3'd5, 32'h0000_FFFF, 32'h0},
    '{1'b0, 3'd5, 32'h0,        32'h0000_FFFF}, // R9
    '{1'b1, 3'd6, 32'h0000_0214, 32'h0},
    '{1'b0, 3'd5, 32'h0,        32'h0010_FFFF}, // R8 set
    '{1'b1, 3'd6, 32'h0000_0103, 32'h0},
    '{1'b0, 3'd5, 32'h0,        32'h0010_FFF7}, // R8 clear
    '{1'b1, 3'd6, 32'h0000_0003, 32'h0},
    '{1'b0, 3'd5, 32'h0,        32'h0010_FFF7}, // R8 nop
    '{1'b1, 3'd5, 32'hFFFF_FFFF, 32'h0},
    '{1'b1, 3'd3, 32'h0000_00FE, 32'h0},
    '{1'b0, 3'd3, 32'h0,        32'hFE},        // R9
    '{1'b0, 3'd1, 32'h0,        32'h0},         // R10
    '{1'b1, 3'd3, 32'h0000_00FF, 32'h0},
    '{1'b1, 3'd0, 32'h0000_0031, 32'h0},
    '{1'b0, 3'd1, 32'h0,        32'h4},         // R7 bad domain
    '{1'b1, 3'd1, 32'h0,        32'h0},
    '{1'b0, 3'd1, 32'h0,        32'h0},         // R7 clear
    '{1'b1, 3'd2, 32'h0000_0002, 32'h0},
    '{1'b0, 3'd2, 32'h0,        32'h2}          // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 port reset state
    chk("R1 pwr", {24'h0, pwr_off}, 32'hFF);
    chk("R1 iso", {24'h0, iso_rel}, 32'h0);
    chk("R1 rst", rst_n, 32'hFFFF_FFFF);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, r);
        chk($sformatf("R9 table entry %0d", i), r, VECS[i].exp);
      end
    end

    // R8 pulse on line 5: low one cycle then high
    wr(3'd6, 32'h0000_0305);
    chk("R8 pulse low", {31'h0, rst_n[5]}, 32'h0);
    @(negedge clk);
    chk("R8 pulse high", rst_n, 32'hFFFF_FFFF);

    // R3 down domain 0, settle 2
    wr(3'd0, 32'h0000_0000);
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      if (k == 1) chk("R4 busy", {31'h0, seq_busy}, 32'h1);
      if (k == 3) chk("R3 rst held", rst_n, 32'hFFFF_FFFF);
      if (k == 4) chk("R3 R6 rst step", rst_n, 32'hFFFE_FFFF);
      if (k == 9) chk("R4 busy before end", {30'h0, seq_busy, seq_done}, 32'h2);
      if (k == 10) chk("R4 done", {30'h0, seq_busy, seq_done}, 32'h1);
      if (k == 11) chk("R4 done one cycle", {31'h0, seq_done}, 32'h0);
    end
    chk("R3 pwr off", {24'h0, pwr_off}, 32'hFF);

    // R2 up domain 0, with rejected writes mid-sequence (R7)
    wr(3'd0, 32'h0000_0001);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      bus_we = 1'b0;
      if (k == 1) begin
        chk("R2 R6 pwr step", {24'h0, pwr_off}, 32'hF7);
        chk("R2 rst still held", rst_n, 32'hFFFE_FFFF);
      end
      if (k == 2) begin bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0; end
      if (k == 3) chk("R2 rst before S", rst_n, 32'hFFFE_FFFF);
      if (k == 4) begin
        chk("R2 rst step", rst_n, 32'hFFFF_FFFF);
        chk("R2 iso held", {24'h0, iso_rel}, 32'h0);
      end
      if (k == 5) begin bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h11; end
      if (k == 6) chk("R2 iso before step", {24'h0, iso_rel}, 32'h0);
      if (k == 7) chk("R2 R6 iso step", {24'h0, iso_rel}, 32'h01);
      if (k == 10) chk("R4 up done", {31'h0, seq_done}, 32'h1);
    end
    rd(3'd3, r);
    chk("R7 pwr write ignored", r, 32'hF7);
    rd(3'd1, r);
    chk("R7 R10 status err and on", r, 32'h104);
    wr(3'd1, 32'h0);

    // R5 domain 2 has no isolation or reset bits
    wr(3'd0, 32'h0000_0021);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) chk("R5 pwr step", {24'h0, pwr_off}, 32'hE7);
      if (k == 5) chk("R5 busy", {30'h0, seq_busy, seq_done}, 32'h2);
      if (k == 6) chk("R5 done", {30'h0, seq_busy, seq_done}, 32'h1);
    end
    chk("R5 iso untouched", {24'h0, iso_rel}, 32'h01);
    chk("R5 rst untouched", rst_n, 32'hFFFF_FFFF);
    rd(3'd1, r);
    chk("R10 status", r, 32'h500);

    // R2 settle 0, domain 1 up
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h0000_0011);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 1) chk("R2 s0 pwr", {24'h0, pwr_off}, 32'hE3);
      if (k == 2) chk("R2 s0 iso held", {24'h0, iso_rel}, 32'h01);
      if (k == 3) chk("R2 s0 iso", {24'h0, iso_rel}, 32'h03);
      if (k == 4) chk("R4 s0 done", {31'h0, seq_done}, 32'h1);
    end
    rd(3'd1, r);
    chk("R10 all on", r, 32'h700);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule